// File: doc/BRIEF.md
# Indexed effective address calculator

This block turns the extension words that trail an operation word into a 32-bit operand address. Words arrive on a valid/ready stream, at most one per cycle. The first word is decoded in one of two layouts. A short layout carries an index selector and an 8-bit displacement. A long layout can drop the base or the index. It announces how many base and outer displacement words follow, and whether one memory-indirect read sits between the two halves of the sum.

The block samples the base register value when the first word is taken. The index comes from an external register file through a 3-bit select and two 32-bit read ports, one for data registers and one for address registers. For indirect forms the block issues one read on a request/acknowledge memory port and holds the request until it is acknowledged. Each address ends with a one-cycle `ea_done` pulse and `ea_addr` holding the result. A reserved encoding ends the sequence with a one-cycle `ea_illegal` pulse instead.

Top module: `idx_ea_calc`

## Requirements
- R1: When bit 8 of the first word is 0 (short layout), the result is base + index + sign-extended bits 7:0. `ea_done` pulses in the second cycle after the edge that accepts the word, and no further words are taken for that address.
- R2: The index source is chosen by bit 15 (0 = data register, 1 = address register), with bits 14:12 driven on `idx_reg_num`. Bit 11 = 0 sign-extends the low 16 bits and bit 11 = 1 uses all 32. Bits 10:9 shift the index left by 0 to 3 places (multiply by 1, 2, 4, 8).
- R3: In the long layout (bit 8 = 1), bit 7 = 1 replaces the base with zero and bit 6 = 1 replaces the index with zero.
- R4: In the long layout, bits 5:4 give the base displacement: 01 means no word, 10 means one word sign-extended to 32 bits, and 11 means two words, high half first.
- R5: A long-layout first word is reserved, and produces `ea_illegal` for one cycle with no `ea_done` and no further words taken, when any of the following holds: bits 5:4 = 00; bit 3 = 1; bits 2:0 = 100; bit 6 = 1 with bit 2 = 1.
- R6: Bits 2:0 = 001, 010 or 011 select pre-indexed indirection. The block reads memory at base + base displacement + index, and the result is the read data + outer displacement.
- R7: Bits 2:0 = 101, 110 or 111 select post-indexed indirection. The block reads memory at base + base displacement, and the result is the read data + index + outer displacement.
- R8: For indirect forms, bits 1:0 give the outer displacement (01 none, 10 one sign-extended word, 11 two words high half first). These words follow all base displacement words. Bits 2:0 = 000 means no indirection, and the result is base + base displacement + index.
- R9: `ext_ready` is high only while the block is idle or still expects displacement words. While `mem_req` waits for `mem_ack`, the request stays high with `mem_addr` unchanged and `ext_ready` is low.
- R10: After reset, `ext_ready` is 1 and `ea_done`, `ea_illegal` and `mem_req` are 0.
- R11: `ea_done` and `ea_illegal` are one-cycle pulses, never high together, and the block is idle (ready) in the cycle of either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_valid | input | 1 | Extension word valid |
| ext_word | input | 16 | Extension word |
| ext_ready | output | 1 | Block can take a word this cycle |
| base_val | input | 32 | Base register value, sampled with the first word |
| idx_reg_num | output | 3 | Index register number for the register file read ports |
| dreg_data | input | 32 | Data register selected by idx_reg_num |
| areg_data | input | 32 | Address register selected by idx_reg_num |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 32 | Indirect read address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Read data |
| ea_addr | output | 32 | Final address, valid with ea_done |
| ea_done | output | 1 | One-cycle completion pulse |
| ea_illegal | output | 1 | One-cycle reserved-encoding pulse |

## Verification
A wrong word count shows at the ports within a few cycles. Either `ext_ready` stays high when the block should be computing, so the next address's first word is swallowed as a displacement and its completion is wrong or missing, or it drops early and the bench's word stalls. A wrong captured base, index or displacement register shows on `mem_addr` in the first cycle of the indirect request, or on `ea_addr` with the very next done pulse. Each reserved encoding is followed at once by a short-layout address, so any word consumed after an illegal encoding surfaces as a miscompare on that next result.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned EXT_W  = 16;
  localparam int unsigned RSEL_W = 3;
  localparam int unsigned D8_W   = 8;
  localparam int unsigned SELB_W = 7;   // bits 15:9 of the first word
  localparam int unsigned CTLB_W = 9;   // bits 8:0 of the first word

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BD   = 3'd1,
    ST_OD   = 3'd2,
    ST_FIN  = 3'd3,
    ST_MEM  = 3'd4
  } ea_state_e;

  typedef enum logic [1:0] {
    IND_NONE = 2'd0,
    IND_PRE  = 2'd1,
    IND_POST = 2'd2
  } ind_mode_e;

  typedef struct packed {
    logic      full;
    logic      base_sup;
    logic      idx_sup;
    logic [1:0] bd_words;
    logic [1:0] od_words;
    ind_mode_e mode;
    logic      illegal;
  } ext_dec_t;

  function automatic logic [ADDR_W-1:0] sext16(input logic [EXT_W-1:0] w);
    return {{(ADDR_W-EXT_W){w[EXT_W-1]}}, w};
  endfunction

  function automatic logic [ADDR_W-1:0] sext8(input logic [D8_W-1:0] b);
    return {{(ADDR_W-D8_W){b[D8_W-1]}}, b};
  endfunction

endpackage

// File: rtl/idx_ea_rst_sync.sv
module idx_ea_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
  import idx_ea_pkg::*;
(
  input  logic [CTLB_W-1:0] ctl,   // bits 8:0 of the first word
  output ext_dec_t          dec
);

  always_comb begin
    dec      = '0;
    dec.mode = IND_NONE;
    dec.full = ctl[8];
    if (ctl[8]) begin
      dec.base_sup = ctl[7];
      dec.idx_sup  = ctl[6];
      unique case (ctl[5:4])
        2'b10:   dec.bd_words = 2'd1;
        2'b11:   dec.bd_words = 2'd2;
        default: dec.bd_words = 2'd0;
      endcase
      unique case (ctl[1:0])
        2'b10:   dec.od_words = 2'd1;
        2'b11:   dec.od_words = 2'd2;
        default: dec.od_words = 2'd0;
      endcase
      if (ctl[2:0] != 3'b000) begin
        dec.mode = ctl[2] ? IND_POST : IND_PRE;
      end
      dec.illegal = (ctl[5:4] == 2'b00) | ctl[3] |
                    (ctl[2:0] == 3'b100) | (ctl[6] & ctl[2]);
    end
  end

endmodule

// File: rtl/idx_ea_index.sv
module idx_ea_index
  import idx_ea_pkg::*;
(
  input  logic [SELB_W-1:0] sel_bits,   // bits 15:9 of the first word
  input  logic [ADDR_W-1:0] dreg_data,
  input  logic [ADDR_W-1:0] areg_data,
  output logic [RSEL_W-1:0] reg_num,
  output logic [ADDR_W-1:0] scaled
);

  logic              use_areg;
  logic              long_idx;
  logic [1:0]        shift;
  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] sized;

  assign use_areg = sel_bits[6];
  assign reg_num  = sel_bits[5:3];
  assign long_idx = sel_bits[2];
  assign shift    = sel_bits[1:0];

  always_comb begin
    raw    = use_areg ? areg_data : dreg_data;
    sized  = long_idx ? raw : sext16(raw[EXT_W-1:0]);
    scaled = sized << shift;
  end

endmodule

// File: rtl/idx_ea_disp.sv
module idx_ea_disp
  import idx_ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_en,
  input  logic [ADDR_W-1:0] init_val,
  input  logic              load_en,
  input  logic              first,
  input  logic              is_long,
  input  logic [EXT_W-1:0]  word,
  output logic [ADDR_W-1:0] value
);

  logic [ADDR_W-1:0] val_q;
  logic [ADDR_W-1:0] val_d;
  logic              val_en;

  always_comb begin
    val_d  = val_q;
    val_en = init_en | load_en;
    if (init_en) begin
      val_d = init_val;
    end else if (load_en) begin
      if (is_long && first)  val_d = {word, {EXT_W{1'b0}}};
      else if (is_long)      val_d = {val_q[ADDR_W-1:EXT_W], word};
      else                   val_d = sext16(word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign value = val_q;

  // R4: the second word of a long displacement leaves the high half in place
  a_r4_long_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !init_en && is_long && !first) |=>
      (value[ADDR_W-1:EXT_W] == $past(value[ADDR_W-1:EXT_W])));

endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_valid,
  input  logic [EXT_W-1:0]  ext_word,
  output logic              ext_ready,
  input  logic [ADDR_W-1:0] base_val,
  output logic [RSEL_W-1:0] idx_reg_num,
  input  logic [ADDR_W-1:0] dreg_data,
  input  logic [ADDR_W-1:0] areg_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              ea_done,
  output logic              ea_illegal
);

  logic rst_s_n;

  idx_ea_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  ext_dec_t dec;

  idx_ea_decode u_dec (
    .ctl (ext_word[CTLB_W-1:0]),
    .dec (dec)
  );

  logic [ADDR_W-1:0] idx_scaled;

  idx_ea_index u_idx (
    .sel_bits  (ext_word[EXT_W-1:CTLB_W]),
    .dreg_data (dreg_data),
    .areg_data (areg_data),
    .reg_num   (idx_reg_num),
    .scaled    (idx_scaled)
  );

  // sequencing state
  ea_state_e         state_q, state_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              ill_q, ill_d;

  // operands captured with the first word
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  ind_mode_e         mode_q;
  logic [1:0]        od_words_q;
  logic              bd_long_q, od_long_q;
  logic              cap_en;

  // result
  logic [ADDR_W-1:0] ea_q, ea_d;
  logic              ea_en;

  // displacement assembly
  logic              disp_init;
  logic [ADDR_W-1:0] bd_init_val;
  logic              bd_load, od_load;
  logic [ADDR_W-1:0] bd_val, od_val;

  logic acc;

  assign ext_ready = (state_q == ST_IDLE) | (state_q == ST_BD) | (state_q == ST_OD);
  assign acc       = ext_valid & ext_ready;

  idx_ea_disp u_bd (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .init_en  (disp_init),
    .init_val (bd_init_val),
    .load_en  (bd_load),
    .first    (cnt_q[1]),
    .is_long  (bd_long_q),
    .word     (ext_word),
    .value    (bd_val)
  );

  idx_ea_disp u_od (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .init_en  (disp_init),
    .init_val ('0),
    .load_en  (od_load),
    .first    (cnt_q[1]),
    .is_long  (od_long_q),
    .word     (ext_word),
    .value    (od_val)
  );

  function automatic ea_state_e after_bd(input logic [1:0] od_words, input ind_mode_e mode);
    if (od_words != 2'd0)    return ST_OD;
    else if (mode != IND_NONE) return ST_MEM;
    else                     return ST_FIN;
  endfunction

  // next-state and datapath
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    done_d      = 1'b0;
    ill_d       = 1'b0;
    cap_en      = 1'b0;
    ea_en       = 1'b0;
    ea_d        = ea_q;
    disp_init   = 1'b0;
    bd_load     = 1'b0;
    od_load     = 1'b0;
    base_d      = dec.base_sup ? '0 : base_val;
    idx_d       = dec.idx_sup  ? '0 : idx_scaled;
    bd_init_val = dec.full ? '0 : sext8(ext_word[D8_W-1:0]);

    unique case (state_q)
      ST_IDLE: begin
        if (acc) begin
          if (dec.illegal) begin
            ill_d = 1'b1;
          end else begin
            cap_en    = 1'b1;
            disp_init = 1'b1;
            if (!dec.full) begin
              state_d = ST_FIN;
              cnt_d   = 2'd0;
            end else if (dec.bd_words != 2'd0) begin
              state_d = ST_BD;
              cnt_d   = dec.bd_words;
            end else begin
              state_d = after_bd(dec.od_words, dec.mode);
              cnt_d   = dec.od_words;
            end
          end
        end
      end
      ST_BD: begin
        if (acc) begin
          bd_load = 1'b1;
          if (cnt_q == 2'd1) begin
            state_d = after_bd(od_words_q, mode_q);
            cnt_d   = od_words_q;
          end else begin
            cnt_d = cnt_q - 2'd1;
          end
        end
      end
      ST_OD: begin
        if (acc) begin
          od_load = 1'b1;
          if (cnt_q == 2'd1) begin
            state_d = (mode_q != IND_NONE) ? ST_MEM : ST_FIN;
            cnt_d   = 2'd0;
          end else begin
            cnt_d = cnt_q - 2'd1;
          end
        end
      end
      ST_FIN: begin
        done_d  = 1'b1;
        ea_en   = 1'b1;
        ea_d    = base_q + bd_val + idx_q;
        state_d = ST_IDLE;
      end
      ST_MEM: begin
        if (mem_ack) begin
          done_d  = 1'b1;
          ea_en   = 1'b1;
          ea_d    = mem_rdata + od_val + ((mode_q == IND_POST) ? idx_q : '0);
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = 2'd0;
      end
    endcase
  end

  assign mem_req  = (state_q == ST_MEM);
  assign mem_addr = base_q + bd_val + ((mode_q == IND_PRE) ? idx_q : '0);

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 2'd0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      ill_q   <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      base_q     <= '0;
      idx_q      <= '0;
      mode_q     <= IND_NONE;
      od_words_q <= 2'd0;
      bd_long_q  <= 1'b0;
      od_long_q  <= 1'b0;
    end else if (cap_en) begin
      base_q     <= base_d;
      idx_q      <= idx_d;
      mode_q     <= dec.mode;
      od_words_q <= dec.od_words;
      bd_long_q  <= (dec.bd_words == 2'd2);
      od_long_q  <= (dec.od_words == 2'd2);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   ea_q <= '0;
    else if (ea_en) ea_q <= ea_d;
  end

  assign ea_addr    = ea_q;
  assign ea_done    = done_q;
  assign ea_illegal = ill_q;

  // R11: completion and reserved-encoding pulses never coincide
  a_r11_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(ea_done && ea_illegal));

  // R11: done lasts exactly one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_s_n)
    ea_done |=> !ea_done);

  // R11: the block is idle and ready in the cycle of a done pulse
  a_r11_idle_on_done: assert property (@(posedge clk) disable iff (!rst_s_n)
    ea_done |-> (ext_ready && !mem_req));

  // R5: after a reserved encoding the block is idle again
  a_r5_idle_after_illegal: assert property (@(posedge clk) disable iff (!rst_s_n)
    ea_illegal |-> (ext_ready && !mem_req));

  // R9: a pending read holds its request and address
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R9: no words are taken while the indirect read is outstanding
  a_r9_no_ready_in_read: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req |-> !ext_ready);

endmodule

// File: tb/test_idx_ea_calc.sv
`timescale 1ns/1ps
module test_idx_ea_calc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_valid = 1'b0;
  logic [15:0] ext_word = '0;
  logic        ext_ready;
  logic [31:0] base_val = '0;
  logic [2:0]  idx_reg_num;
  logic [31:0] dreg_data, areg_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] ea_addr;
  logic        ea_done, ea_illegal;

  always #2 clk = ~clk;   // 250 MHz

  idx_ea_calc i_idx_ea_calc (
    .clk, .rst_n, .ext_valid, .ext_word, .ext_ready, .base_val,
    .idx_reg_num, .dreg_data, .areg_data, .mem_req, .mem_addr,
    .mem_ack, .mem_rdata, .ea_addr, .ea_done, .ea_illegal
  );

  logic [31:0] dregs [8];
  logic [31:0] aregs [8];
  assign dreg_data = dregs[idx_reg_num];
  assign areg_data = aregs[idx_reg_num];

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_addr_q [$];
  bit          exp_ill_q  [$];
  string       exp_tag_q  [$];
  logic [31:0] exp_mem_q  [$];
  string       exp_mtag_q [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hA5A5_0F0F;
  endfunction

  function automatic logic [31:0] sx16(input logic [15:0] w);
    return {{16{w[15]}}, w};
  endfunction

  // index per R2
  function automatic logic [31:0] idx_model(input logic [15:0] w);
    logic [31:0] r;
    r = w[15] ? aregs[w[14:12]] : dregs[w[14:12]];
    if (!w[11]) r = sx16(r[15:0]);
    return r << w[10:9];
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (ea_done || ea_illegal)) begin
      check(!(ea_done && ea_illegal), "R11 done and illegal together",
            {31'b0, ea_done && ea_illegal}, 32'h0);
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R11 unexpected completion", {30'b0, ea_done, ea_illegal}, 32'h0);
      end else begin
        logic [31:0] e;
        bit          ei;
        string       t;
        e  = exp_addr_q.pop_front();
        ei = exp_ill_q.pop_front();
        t  = exp_tag_q.pop_front();
        if (ei) begin
          check(ea_illegal, {t, " illegal flag"}, {31'b0, ea_illegal}, 32'h1);
        end else begin
          check(ea_done, {t, " done flag"}, {31'b0, ea_done}, 32'h1);
          check(ea_addr == e, {t, " address"}, ea_addr, e);
        end
      end
    end
  end

  // memory responder, two wait cycles per read
  int mem_wait = 0;
  always @(negedge clk) begin
    if (rst_n && mem_req && !mem_ack) begin
      check(!ext_ready, "R9 ready low during indirect read", {31'b0, ext_ready}, 32'h0);
      if (mem_wait == 2) begin
        if (exp_mem_q.size() == 0) begin
          check(1'b0, "R9 unexpected memory read", mem_addr, 32'h0);
        end else begin
          logic [31:0] ma;
          string       mt;
          ma = exp_mem_q.pop_front();
          mt = exp_mtag_q.pop_front();
          check(mem_addr == ma, {mt, " read address"}, mem_addr, ma);
        end
        mem_rdata <= mem_model(mem_addr);
        mem_ack   <= 1'b1;
        mem_wait  <= 0;
      end else begin
        mem_wait <= mem_wait + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    while (!ext_ready) @(negedge clk);
    ext_valid = 1'b1;
    ext_word  = w;
    @(negedge clk);
    ext_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_addr_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: computes the expected item from the requirements and pushes it
  task automatic run_ea(input logic [31:0] base, input logic [15:0] w0,
                        input logic [31:0] bd, input logic [31:0] od, input string tag);
    logic [31:0] ix, b, bdv, odv, ma, e;
    logic [2:0]  iis;
    bit          ill;
    iis = w0[2:0];
    ill = w0[8] && ((w0[5:4] == 2'b00) || w0[3] || (iis == 3'b100) || (w0[6] && iis[2]));
    ix  = idx_model(w0);
    base_val = base;
    if (ill) begin
      exp_addr_q.push_back(32'h0); exp_ill_q.push_back(1'b1); exp_tag_q.push_back(tag);
      send_word(w0);
    end else if (!w0[8]) begin
      e = base + {{24{w0[7]}}, w0[7:0]} + ix;
      exp_addr_q.push_back(e); exp_ill_q.push_back(1'b0); exp_tag_q.push_back(tag);
      send_word(w0);
    end else begin
      b   = w0[7] ? 32'h0 : base;
      ix  = w0[6] ? 32'h0 : ix;
      bdv = (w0[5:4] == 2'b10) ? sx16(bd[15:0]) : (w0[5:4] == 2'b11) ? bd : 32'h0;
      odv = (iis[1:0] == 2'b10) ? sx16(od[15:0]) : (iis[1:0] == 2'b11) ? od : 32'h0;
      if (iis == 3'b000) begin
        e = b + bdv + ix;
      end else begin
        ma = b + bdv + (iis[2] ? 32'h0 : ix);
        exp_mem_q.push_back(ma); exp_mtag_q.push_back(tag);
        e = mem_model(ma) + odv + (iis[2] ? ix : 32'h0);
      end
      exp_addr_q.push_back(e); exp_ill_q.push_back(1'b0); exp_tag_q.push_back(tag);
      send_word(w0);
      if (w0[5:4] == 2'b10) send_word(bd[15:0]);
      if (w0[5:4] == 2'b11) begin send_word(bd[31:16]); send_word(bd[15:0]); end
      if (iis != 3'b000 && iis[1:0] == 2'b10) send_word(od[15:0]);
      if (iis != 3'b000 && iis[1:0] == 2'b11) begin send_word(od[31:16]); send_word(od[15:0]); end
    end
    drain();
    check(ext_ready, {tag, " R9 ready when idle"}, {31'b0, ext_ready}, 32'h1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired, actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    dregs[0] = 32'h0000_0010; dregs[1] = 32'h0000_0100; dregs[2] = 32'hFFFF_FFF0;
    dregs[3] = 32'h1234_F000; dregs[4] = 32'h0000_0003; dregs[5] = 32'h7FFF_0002;
    dregs[6] = 32'h0000_8001; dregs[7] = 32'hDEAD_0044;
    aregs[0] = 32'h0010_0000; aregs[1] = 32'h0000_2000; aregs[2] = 32'h8000_0000;
    aregs[3] = 32'h0000_0800; aregs[4] = 32'h0003_0020; aregs[5] = 32'h0000_0400;
    aregs[6] = 32'h0001_FFFF; aregs[7] = 32'h0000_0004;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(ext_ready,   "R10 ready after reset",   {31'b0, ext_ready},   32'h1);
    check(!ea_done,    "R10 done after reset",    {31'b0, ea_done},     32'h0);
    check(!ea_illegal, "R10 illegal after reset", {31'b0, ea_illegal},  32'h0);
    check(!mem_req,    "R10 mem_req after reset", {31'b0, mem_req},     32'h0);

    // short layout
    run_ea(32'h0000_4000, 16'h30F0, 32'h0, 32'h0, "R1 R2 short D3 word negative disp");
    run_ea(32'h1000_0000, 16'hDE12, 32'h0, 32'h0, "R1 R2 short A5 long scale 8");
    run_ea(32'hFFFF_FF00, 16'h627F, 32'h0, 32'h0, "R1 R2 short D6 word scale 2");
    // long layout, no indirection
    run_ea(32'h0002_0000, 16'h1D20, 32'h0000_8000, 32'h0, "R4 word base disp sign extended");
    run_ea(32'h7777_7777, 16'hA1F0, 32'h1234_5678, 32'h0, "R3 R4 base and index suppressed long disp");
    run_ea(32'h0000_0100, 16'h7150, 32'h0, 32'h0, "R3 index suppressed null disp");
    run_ea(32'h5555_0000, 16'h8B90, 32'h0, 32'h0, "R3 base suppressed null disp");
    // indirection
    run_ea(32'h0000_3000, 16'h3322, 32'h0000_0040, 32'h0000_FFF0, "R6 R8 pre-indexed word outer");
    run_ea(32'h0100_0000, 16'hCD37, 32'h0001_0000, 32'h8000_0004, "R7 R8 post-indexed long outer");
    run_ea(32'h0000_0200, 16'h0151, 32'h0, 32'h0, "R6 R8 pre-indexed null outer index suppressed");
    run_ea(32'h0000_0300, 16'hF725, 32'h0000_FFFE, 32'h0, "R7 post-indexed null outer");
    run_ea(32'hABCD_0000, 16'h5996, 32'h0, 32'h0000_7FFF, "R7 R8 post-indexed word outer base suppressed");
    // reserved encodings, each followed by a short layout address
    run_ea(32'h0000_1111, 16'h0100, 32'h0, 32'h0, "R5 base disp size 00");
    run_ea(32'h0000_4000, 16'h30F0, 32'h0, 32'h0, "R5 no word consumed after illegal (bd 00)");
    run_ea(32'h0000_1111, 16'h0114, 32'h0, 32'h0, "R5 indirection code 100");
    run_ea(32'h0000_5000, 16'hDE12, 32'h0, 32'h0, "R5 no word consumed after illegal (100)");
    run_ea(32'h0000_1111, 16'h0156, 32'h0, 32'h0, "R5 suppressed index with post code");
    run_ea(32'h0000_6000, 16'h627F, 32'h0, 32'h0, "R5 no word consumed after illegal (IS post)");
    run_ea(32'h0000_1111, 16'h0118, 32'h0, 32'h0, "R5 bit 3 set");
    run_ea(32'h0000_7000, 16'h30F0, 32'h0, 32'h0, "R5 no word consumed after illegal (bit 3)");
    // back-to-back indirect forms
    run_ea(32'h0000_3000, 16'h3322, 32'h0000_0040, 32'h0000_0002, "R6 pre-indexed repeat");
    run_ea(32'h0100_0000, 16'hCD37, 32'hFFFF_0000, 32'h0000_0010, "R7 post-indexed repeat");

    repeat (3) @(negedge clk);
    check(exp_mem_q.size() == 0, "R9 all reads issued", exp_mem_q.size(), 32'h0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule